// File: doc/BRIEF.md
# Run-Length Expander for a Parallel-Port Receive Stream

This unit sits behind the reverse-direction receiver of an extended-capability parallel port and in front of whatever consumes the received bytes. Each incoming item is one byte plus a flag marking it as a command. A command byte with its top bit clear holds a repeat count for the next data byte. A command byte with its top bit set holds a channel address. Data bytes are sent on unchanged. If a repeat count is pending, the data byte is sent that many times plus one.

Both the input side and the data output use valid/ready handshakes. The output holds its byte under backpressure. The input stays closed while a run is still being played out. Addresses leave on a separate one-cycle strobe and never enter the data stream.

Top module: `rle_expander`

## Requirements
- R1: After reset `out_valid` and `adr_valid` are low and `in_ready` is high.
- R2: A data item (`in_cmd`=0) with no count pending appears once on `out_byte`.
- R3: A command with bit 7 = 0 and bits 6:0 = N makes the next data byte appear N+1 times. 0 gives one copy and 127 gives 128.
- R4: A count applies only to the first data byte after it. The data byte after that appears once.
- R5: When two count commands arrive with no data byte between them, only the later count is used.
- R6: A command with bit 7 = 1 raises `adr_valid` for exactly one cycle, with bits 6:0 on `adr_value`. It produces nothing on the data output.
- R7: An address command discards any pending count, so the next data byte appears once.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_byte` does not change.
- R9: `in_ready` is low whenever the output holds a byte that cannot leave this cycle. This covers two cases: `out_ready` is low, or further copies of the run remain.
- R10: Reset discards a pending count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input item present |
| in_cmd | input | 1 | 1: item is a command byte, 0: data byte |
| in_byte | input | BYTE_W | Input byte |
| in_ready | output | 1 | Input item taken this cycle when high together with in_valid |
| out_valid | output | 1 | Output byte present |
| out_byte | output | BYTE_W | Output data byte |
| out_ready | input | 1 | Consumer takes the output byte |
| adr_valid | output | 1 | One-cycle strobe for a received address |
| adr_value | output | BYTE_W-1 | Received channel address |

## Verification
The bench builds the block with the default byte width of 8. At that width the counter field is seven bits, so the largest run of 128 copies is reached and fully checked. A pseudo-random stall pattern on `out_ready` is switched on during part of the stream. Under those stalls, runs, plain bytes and addresses are interleaved, which exercises holding the output byte, closing the input and back-to-back acceptance when the last copy leaves.

// File: rtl/rle_expander.sv
module rle_expander #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_cmd,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              in_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte,
  input  logic              out_ready,
  output logic              adr_valid,
  output logic [BYTE_W-2:0] adr_value
);
  localparam int FLD_W = BYTE_W - 1;

  logic [FLD_W-1:0] pend;
  logic [FLD_W-1:0] rem;

  wire take  = in_valid && in_ready;
  wire drain = out_valid && out_ready;

  assign in_ready = !out_valid || (out_ready && rem == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= '0;
      rem       <= '0;
      out_valid <= 1'b0;
      out_byte  <= '0;
      adr_valid <= 1'b0;
      adr_value <= '0;
    end else begin
      adr_valid <= 1'b0;
      if (drain) begin
        if (rem != '0) rem <= rem - 1'b1;
        else           out_valid <= 1'b0;
      end
      if (take) begin
        if (in_cmd) begin
          if (in_byte[BYTE_W-1]) begin
            adr_valid <= 1'b1;
            adr_value <= in_byte[FLD_W-1:0];
            pend      <= '0;
          end else begin
            pend <= in_byte[FLD_W-1:0];
          end
        end else begin
          out_valid <= 1'b1;
          out_byte  <= in_byte;
          rem       <= pend;
          pend      <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/rle_expander_chk.sv
module rle_expander_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_cmd,
  input logic [BYTE_W-1:0] in_byte,
  input logic              in_ready,
  input logic              out_valid,
  input logic [BYTE_W-1:0] out_byte,
  input logic              out_ready,
  input logic              adr_valid,
  input logic [BYTE_W-2:0] rem
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && !adr_valid));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));

  // R9
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R3
  repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && rem != '0) |=> (out_valid && $stable(out_byte)));

  // R6
  adr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adr_valid |-> $past(in_valid && in_ready && in_cmd && in_byte[BYTE_W-1]));

  // R6
  adr_nodata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_cmd && !out_valid) |=> !out_valid);
endmodule

bind rle_expander rle_expander_chk #(.BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/tb_rle_expander.sv
module tb_rle_expander;
  localparam int CLK_PERIOD = 10;
  localparam int BYTE_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_cmd = 1'b0;
  logic [BYTE_W-1:0] in_byte = '0;
  logic in_ready;
  logic out_valid;
  logic [BYTE_W-1:0] out_byte;
  logic out_ready = 1'b1;
  logic adr_valid;
  logic [BYTE_W-2:0] adr_value;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int pend_m = 0;
  logic bp_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  logic [7:0] exp_q[$];
  bit         last_q[$];
  int         tag_q[$];
  logic [6:0] adr_q[$];
  int         adr_tag_q[$];

  logic prev_stall = 1'b0;
  logic [7:0] prev_byte = '0;

  rle_expander #(.BYTE_W(BYTE_W)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready <= bp_en ? lfsr[3] : 1'b1;
  end

  task automatic check(input bit ok, input int tag, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d actual=0x%0h expected=0x%0h", tag, act, exp_v);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      // R8: stalled byte held
      if (prev_stall) check(out_valid && out_byte == prev_byte, 8, out_byte, prev_byte);
      // R9: closed input while stalled or copies remain
      if (out_valid && (!out_ready || (last_q.size() > 0 && !last_q[0])))
        check(!in_ready, 9, in_ready, 0);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(0, 6, out_byte, 0);
        else begin
          check(out_byte == exp_q[0], tag_q[0], out_byte, exp_q[0]);
          void'(exp_q.pop_front()); void'(last_q.pop_front()); void'(tag_q.pop_front());
        end
      end
      if (adr_valid) begin
        if (adr_q.size() == 0) check(0, 6, adr_value, 0);
        else begin
          check(adr_value == adr_q[0], adr_tag_q[0], adr_value, adr_q[0]);
          void'(adr_q.pop_front()); void'(adr_tag_q.pop_front());
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_byte  = out_byte;
    end else prev_stall = 1'b0;
  end

  always @(negedge clk) begin
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic send(input bit c, input logic [7:0] b, input int tag);
    if (c && b[7]) begin
      adr_q.push_back(b[6:0]); adr_tag_q.push_back(tag); pend_m = 0;
    end else if (c) pend_m = b[6:0];
    else begin
      for (int i = 0; i <= pend_m; i++) begin
        exp_q.push_back(b); last_q.push_back(i == pend_m); tag_q.push_back(tag);
      end
      pend_m = 0;
    end
    @(negedge clk);
    in_valid = 1'b1; in_cmd = c; in_byte = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_cmd = 1'b0;
  endtask

  task automatic drain_all();
    while (exp_q.size() != 0 || adr_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(in_ready == 1'b1, 1, in_ready, 1);
    check(out_valid == 1'b0, 1, out_valid, 0);
    check(adr_valid == 1'b0, 1, adr_valid, 0);

    // R2
    send(0, 8'h11, 2); send(0, 8'h22, 2);
    // R3 and R4
    send(1, 8'h00, 3); send(0, 8'hAB, 3);
    send(1, 8'h03, 3); send(0, 8'h5C, 3); send(0, 8'h77, 4);
    send(1, 8'h7F, 3); send(0, 8'hE1, 3); send(0, 8'h78, 4);
    // R5
    send(1, 8'h05, 5); send(1, 8'h02, 5); send(0, 8'h33, 5);
    // R6 and R7
    send(1, 8'h04, 7); send(1, 8'h85, 6); send(0, 8'h44, 7);
    drain_all();

    // R8 and R9 under stalls
    bp_en = 1'b1;
    send(1, 8'h06, 8); send(0, 8'h9A, 9);
    send(0, 8'h01, 8); send(0, 8'h02, 8);
    send(1, 8'hFF, 6); send(1, 8'h01, 9); send(0, 8'hC3, 9);
    send(1, 8'h10, 9); send(0, 8'h3C, 8); send(1, 8'hA0, 6);
    drain_all();
    bp_en = 1'b0;
    repeat (2) @(negedge clk);

    // R10
    send(1, 8'h09, 10);
    rst_n = 1'b0; pend_m = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && adr_valid == 1'b0, 1, out_valid, 0);
    send(0, 8'h66, 10);
    drain_all();

    check(exp_q.size() == 0, 6, exp_q.size(), 0);
    check(adr_q.size() == 0, 6, adr_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule